// File: doc/BRIEF.md
# Per-Sector Access Lock Register File

This block holds a small lock register for each sector of a flash array and uses it to decide whether an access to that sector may proceed. A host writes a 3-bit lock value to a chosen sector through a simple write port, and it can read any sector's value back as an 8-bit word. Each value carries three flags: a write lock that refuses program and erase, a read lock that refuses array reads, and a one-way lock-down flag. Once lock-down is set, the sector's other two flags are frozen. Only a hardware reset can clear them again.

On the access side, the array address selects a sector through its top bits. The block reports a read permit and a write permit for that sector. It forwards a request to the array only when the access is allowed. A refused read returns all-ones data to the host. Any refused access raises a single-cycle violation pulse on the following cycle.

Two active-low reset inputs are combined. Either one clears every sector to its default. Assertion of the reset is asynchronous, and its release is synchronised to the clock.

Top module: `seclock_regs`

## Requirements
- R1: While either `rst_n` or `init_n` is low, and after it is released, every sector reads back 0x01: write-locked, not read-locked, not locked down.
- R2: The readback word places write-lock at bit 0, lock-down at bit 1 and read-lock at bit 2. Bits 7..3 always read zero, whatever was written to them.
- R3: A write with `cfg_we` high to a sector whose lock-down is clear loads `cfg_wdata[2:0]` into that sector on the next clock edge. All other sectors keep their values.
- R4: A program or erase access (`acc_write`=1) to a sector with write-lock 1 is not forwarded (`arr_req`=0) and `wr_permit` is 0. With write-lock 0 it is forwarded and `wr_permit` is 1.
- R5: A read access (`acc_write`=0) to a sector with read-lock 1 is not forwarded, drives `host_rdata` to 0xFF and shows `rd_permit`=0. With read-lock 0 it is forwarded and `host_rdata` equals `arr_rdata`.
- R6: A refused access raises `viol` for exactly one cycle, in the cycle after the access. A permitted access leaves `viol` low.
- R7: A register write cannot clear a set lock-down bit.
- R8: While lock-down is set, writes that try to change read-lock or write-lock leave the sector value, and its effect on accesses, unchanged.
- R9: A write that changes only lock-down from 0 to 1 is accepted.
- R10: Pulsing `init_n` low alone clears lock-down and restores the default, after which the sector is writable again.
- R11: The sector of an access is `acc_addr[ADDR_W-1 -: 3]`, so an address one below a sector base belongs to the lower sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| init_n | input | 1 | Second active-low reset, same effect |
| cfg_we | input | 1 | Lock register write strobe |
| cfg_sect | input | 3 | Sector written |
| cfg_wdata | input | 8 | Write data; bits 2..0 used |
| cfg_rsect | input | 3 | Sector read back |
| cfg_rdata | output | 8 | Readback value of `cfg_rsect` |
| acc_valid | input | 1 | Array access request |
| acc_write | input | 1 | 1 = program/erase, 0 = read |
| acc_addr | input | 22 | Array address |
| arr_rdata | input | 8 | Data returned by the array |
| rd_permit | output | 1 | Reads allowed in addressed sector |
| wr_permit | output | 1 | Program/erase allowed in addressed sector |
| arr_req | output | 1 | Access forwarded to the array |
| arr_we | output | 1 | Forwarded access is a program/erase |
| host_rdata | output | 8 | Read data to host, 0xFF when refused |
| viol | output | 1 | One-cycle access violation pulse |

## Verification
The hardest state to reach is a locked-down sector, together with the proof that only a reset clears it. A sector frozen by lock-down looks the same at the ports as a sector that simply ignored one write. The stimulus therefore first sets lock-down on a write-locked sector through a write that changes nothing else. It then issues writes that try to clear each flag and retries a program into that sector. Next it pulses only the second reset input. Finally it shows that the same sector accepts a write that opens it fully.

// File: rtl/seclock_pkg.sv
package seclock_pkg;
  localparam int LOCK_W = 3;
  // Field positions are visible in the readback word.
  localparam int WL_BIT = 0;
  localparam int LD_BIT = 1;
  localparam int RL_BIT = 2;

  typedef struct packed {
    logic rl;  // bit 2: read lock
    logic ld;  // bit 1: lock-down
    logic wl;  // bit 0: write lock
  } lock_t;

  localparam lock_t LOCK_DEFAULT = '{rl: 1'b0, ld: 1'b0, wl: 1'b1};
endpackage

// File: rtl/seclock_rst_sync.sv
module seclock_rst_sync (
  input  logic clk,
  input  logic arst_a_n,
  input  logic arst_b_n,
  output logic rst_n_o
);
  logic comb_n;
  logic [1:0] sync_q;

  assign comb_n = arst_a_n & arst_b_n;

  always_ff @(posedge clk or negedge comb_n) begin
    if (!comb_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/seclock_cell.sv
module seclock_cell
  import seclock_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  lock_t wr_val,
  output lock_t state_o
);
  lock_t cur_q, cur_d;

  // A set lock-down blocks every change, including to itself.
  always_comb begin
    cur_d = cur_q;
    if (!cur_q.ld) cur_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cur_q <= LOCK_DEFAULT;
    else if (wr_en) cur_q <= cur_d;
  end

  assign state_o = cur_q;
endmodule

// File: rtl/seclock_gate.sv
module seclock_gate
  import seclock_pkg::*;
#(
  parameter int NUM_SECT = 8,
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 8,
  localparam int SEL_W   = $clog2(NUM_SECT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  lock_t [NUM_SECT-1:0]   lock_i,
  input  logic                   acc_valid,
  input  logic                   acc_write,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [DATA_W-1:0]      arr_rdata,
  output logic                   rd_permit,
  output logic                   wr_permit,
  output logic                   arr_req,
  output logic                   arr_we,
  output logic [DATA_W-1:0]      host_rdata,
  output logic                   viol
);
  logic [SEL_W-1:0] sect;
  lock_t            cur;
  logic             refused;
  logic             viol_d, viol_q;

  assign sect      = acc_addr[ADDR_W-1 -: SEL_W];
  assign cur       = lock_i[sect];
  assign rd_permit = ~cur.rl;
  assign wr_permit = ~cur.wl;
  assign refused   = acc_write ? ~wr_permit : ~rd_permit;
  assign arr_req   = acc_valid & ~refused;
  assign arr_we    = arr_req & acc_write;
  assign host_rdata = rd_permit ? arr_rdata : {DATA_W{1'b1}};

  always_comb viol_d = acc_valid & refused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  assign viol = viol_q;
endmodule

// File: rtl/seclock_regs.sv
module seclock_regs
  import seclock_pkg::*;
#(
  parameter int NUM_SECT = 8,
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 8,
  localparam int SEL_W   = $clog2(NUM_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sect,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [SEL_W-1:0]  cfg_rsect,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              rd_permit,
  output logic              wr_permit,
  output logic              arr_req,
  output logic              arr_we,
  output logic [DATA_W-1:0] host_rdata,
  output logic              viol
);
  logic                 rst_sync_n;
  lock_t [NUM_SECT-1:0] lock_q;
  lock_t                wr_val;
  logic                 unused_rsvd;

  assign wr_val      = lock_t'(cfg_wdata[LOCK_W-1:0]);
  assign unused_rsvd = ^cfg_wdata[DATA_W-1:LOCK_W];

  seclock_rst_sync u_rst (
    .clk      (clk),
    .arst_a_n (rst_n),
    .arst_b_n (init_n),
    .rst_n_o  (rst_sync_n)
  );

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
    logic hit;
    assign hit = cfg_we && (cfg_sect == SEL_W'(i));
    seclock_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (hit),
      .wr_val  (wr_val),
      .state_o (lock_q[i])
    );
  end

  assign cfg_rdata = {{(DATA_W-LOCK_W){1'b0}}, lock_q[cfg_rsect]};

  seclock_gate #(
    .NUM_SECT (NUM_SECT),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_gate (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .lock_i     (lock_q),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .arr_rdata  (arr_rdata),
    .rd_permit  (rd_permit),
    .wr_permit  (wr_permit),
    .arr_req    (arr_req),
    .arr_we     (arr_we),
    .host_rdata (host_rdata),
    .viol       (viol)
  );
endmodule

// File: rtl/seclock_chk.sv
module seclock_chk
  import seclock_pkg::*;
#(
  parameter int NUM_SECT = 8,
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 8,
  localparam int SEL_W   = $clog2(NUM_SECT)
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input lock_t [NUM_SECT-1:0] lock_q,
  input logic [DATA_W-1:0]    cfg_rdata,
  input logic                 acc_valid,
  input logic                 acc_write,
  input logic [ADDR_W-1:0]    acc_addr,
  input logic                 arr_req,
  input logic [DATA_W-1:0]    host_rdata,
  input logic                 viol
);
  logic [SEL_W-1:0] a_sect;
  lock_t            a_lock;
  logic             a_bad;

  assign a_sect = acc_addr[ADDR_W-1 -: SEL_W];
  assign a_lock = lock_q[a_sect];
  assign a_bad  = acc_write ? a_lock.wl : a_lock.rl;

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_rdata[DATA_W-1:LOCK_W] == '0);

  a_r4_wr_refused: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_write && a_lock.wl) |-> !arr_req);

  a_r5_rd_refused: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && !acc_write && a_lock.rl) |-> (!arr_req && host_rdata == '1));

  a_r6_viol_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && a_bad) |=> viol);

  a_r6_viol_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(acc_valid && a_bad) |=> !viol);

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_chk
    a_r7_ld_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
      lock_q[i].ld |=> lock_q[i].ld);
    a_r8_ld_freeze: assert property (@(posedge clk) disable iff (!rst_sync_n)
      lock_q[i].ld |=> $stable(lock_q[i]));
  end
endmodule

bind seclock_regs seclock_chk #(
  .NUM_SECT (NUM_SECT),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .lock_q     (lock_q),
  .cfg_rdata  (cfg_rdata),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_addr   (acc_addr),
  .arr_req    (arr_req),
  .host_rdata (host_rdata),
  .viol       (viol)
);

// File: tb/tb_seclock_regs.sv
module tb_seclock_regs;
  localparam int CLK_P = 10;
  localparam int AW    = 22;
  localparam logic [7:0] ARR_DATA = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n, init_n, cfg_we, acc_valid, acc_write;
  logic [2:0] cfg_sect, cfg_rsect;
  logic [7:0] cfg_wdata, cfg_rdata, arr_rdata, host_rdata;
  logic [AW-1:0] acc_addr;
  logic       rd_permit, wr_permit, arr_req, arr_we, viol;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // Scoreboard queues: cycle to compare, signal id, expected value, label.
  int         q_when[$];
  int         q_sig[$];
  logic [7:0] q_exp[$];
  string      q_req[$];

  seclock_regs dut (
    .clk(clk), .rst_n(rst_n), .init_n(init_n),
    .cfg_we(cfg_we), .cfg_sect(cfg_sect), .cfg_wdata(cfg_wdata),
    .cfg_rsect(cfg_rsect), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .arr_rdata(arr_rdata), .rd_permit(rd_permit), .wr_permit(wr_permit),
    .arr_req(arr_req), .arr_we(arr_we), .host_rdata(host_rdata), .viol(viol)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] sample(int s);
    case (s)
      0: sample = cfg_rdata;
      1: sample = host_rdata;
      2: sample = {7'd0, arr_req};
      3: sample = {7'd0, viol};
      4: sample = {7'd0, rd_permit};
      default: sample = {7'd0, wr_permit};
    endcase
  endfunction

  // Monitor: compares every item due in the current cycle at the falling edge.
  always @(negedge clk) begin
    while (q_when.size() > 0 && q_when[0] == cyc) begin
      logic [7:0] got;
      got = sample(q_sig[0]);
      total++;
      if (got !== q_exp[0]) begin
        bad++;
        $display("FAIL %s: got %h expected %h", q_req[0], got, q_exp[0]);
      end
      void'(q_when.pop_front()); void'(q_sig.pop_front());
      void'(q_exp.pop_front());  void'(q_req.pop_front());
    end
  end

  task automatic push(int w, int s, logic [7:0] e, string r);
    q_when.push_back(w); q_sig.push_back(s); q_exp.push_back(e); q_req.push_back(r);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [2:0] s, logic [7:0] d);
    step(); cfg_we = 1'b1; cfg_sect = s; cfg_wdata = d;
    step(); cfg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] s, logic [7:0] e, string r);
    step(); cfg_rsect = s;
    push(cyc, 0, e, r);
  endtask

  // Drives one access; expectations follow from the permits the sector should give.
  task automatic acc(logic [AW-1:0] a, logic w, logic rp, logic wp, string r);
    logic refused;
    refused = w ? !wp : !rp;
    step(); acc_valid = 1'b1; acc_write = w; acc_addr = a;
    push(cyc, 4, {7'd0, rp}, r);
    push(cyc, 5, {7'd0, wp}, r);
    push(cyc, 2, {7'd0, !refused}, r);
    if (!w) push(cyc, 1, rp ? ARR_DATA : 8'hFF, r);
    push(cyc + 1, 3, {7'd0, refused}, {r, " viol"});
    push(cyc + 2, 3, 8'h00, "R6 viol one cycle");
    step(); acc_valid = 1'b0;
    step();
  endtask

  function automatic logic [AW-1:0] addr_of(int s);
    return {3'(s), 19'h00123};
  endfunction

  initial begin
    rst_n = 1'b0; init_n = 1'b1; cfg_we = 1'b0; cfg_sect = '0; cfg_wdata = '0;
    cfg_rsect = '0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
    arr_rdata = ARR_DATA;
    repeat (5) step();
    rst_n = 1'b1;
    repeat (3) step();

    for (int s = 0; s < 8; s++) rd(3'(s), 8'h01, "R1 default after rst_n");

    acc(addr_of(3), 1'b0, 1'b1, 1'b0, "R5 read open sector");
    acc(addr_of(3), 1'b1, 1'b1, 1'b0, "R4 program refused by default");

    wr(3'd3, 8'h00);
    rd(3'd3, 8'h00, "R3 write opens sector 3");
    rd(3'd2, 8'h01, "R3 other sector untouched");
    acc(addr_of(3), 1'b1, 1'b1, 1'b1, "R4 program allowed");

    wr(3'd5, 8'hFC);
    rd(3'd5, 8'h04, "R2 reserved bits read zero, read-lock at bit 2");
    acc(addr_of(5), 1'b0, 1'b0, 1'b1, "R5 read refused");
    acc(addr_of(5), 1'b1, 1'b0, 1'b1, "R4 program allowed in read-locked sector");
    acc({3'd5, 19'd0} - 22'd1, 1'b0, 1'b1, 1'b0, "R11 address below base is sector 4");

    wr(3'd6, 8'h03);
    rd(3'd6, 8'h03, "R9 lock-down-only write accepted");
    wr(3'd6, 8'h00);
    rd(3'd6, 8'h03, "R7 lock-down not cleared by write");
    wr(3'd6, 8'h04);
    rd(3'd6, 8'h03, "R8 frozen read-lock");
    acc(addr_of(6), 1'b1, 1'b1, 1'b0, "R8 program still refused");

    wr(3'd1, 8'h06);
    rd(3'd1, 8'h06, "R3 set lock-down with read-lock");
    acc(addr_of(1), 1'b0, 1'b0, 1'b1, "R5 read refused in locked-down sector");

    step(); init_n = 1'b0;
    repeat (3) step();
    init_n = 1'b1;
    repeat (3) step();
    rd(3'd6, 8'h01, "R10 init_n clears lock-down");
    rd(3'd1, 8'h01, "R10 init_n restores default");
    rd(3'd3, 8'h01, "R1 default after init_n");
    wr(3'd6, 8'h00);
    rd(3'd6, 8'h00, "R10 sector writable after reset");

    repeat (4) step();
    if (q_when.size() != 0) begin
      bad++; total++;
      $display("FAIL scoreboard: got %0d pending expected 0", q_when.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule